// File: doc/BRIEF.md
# Patterned Line Rasterizer

This block walks a straight line between two pixel positions and emits one pixel per clock cycle, together with a write enable and the colour to write. It moves one unit along the longer (major) axis on every pixel. A fractional accumulator decides when the shorter (minor) axis also moves. The accumulator starts from a programmable value, normally 0x800, which is half of its 12-bit fractional range.

A 16-bit on/off pattern is laid along the line, and a 4-bit wrap index selects the last pattern bit that is used. This gives solid, dashed or dotted lines. Pixels whose pattern bit is on are written in the foreground colour. Pixels whose bit is off are either skipped or painted in the background colour, depending on a flag.

A one-cycle `start` latches every setting. `busy` stays high through setup and drawing. `done` pulses for one cycle after the last pixel. The increment that the accumulator adds on each step is computed at the start of each draw by a bit-serial divider.

Top module: `line_raster`

## Requirements
- R1: While the block is idle, a high `start` latches the endpoints, error seeds, pattern, wrap index, colours and background flag, and `busy` is high from the next cycle on. While `busy` is high, `start` and all setting inputs are ignored.
- R2: The major axis is X when |x1-x0| >= |y1-y0|, otherwise Y. Between consecutive pixels the major coordinate changes by exactly one, toward the end point.
- R3: A line emits exactly major-delta + 1 pixels (`pixValid` high). The first pixel is (x0,y0) and the last pixel's major coordinate equals the end point's.
- R4: The step increment is floor(minorDelta*4096/majorDelta), or 0 for a zero-length line. The accumulator starts at the minor axis's seed (`errInitY` for an X-major line, `errInitX` for a Y-major line). After each pixel the increment is added. When the sum reaches 4096 or more, the minor coordinate moves one unit toward the end point and 4096 is subtracted.
- R5: The pattern index is 0 for the first pixel and advances by one on every pixel, whether or not that pixel is written. After the index equal to `patCount` it returns to 0. Bit n of `pattern` governs index n.
- R6: A pixel whose pattern bit is 1 has `pixWe` = 1 and `pixColor` = `fgColor`.
- R7: A pixel whose pattern bit is 0 has `pixWe` = 0 when `bgEnable` is 0. When `bgEnable` is 1 it has `pixWe` = 1 and `pixColor` = `bgColor`.
- R8: `done` is high for exactly one cycle: the cycle right after the last pixel. In that cycle `busy` and `pixValid` are low.
- R9: When the start and end points are equal, the block emits one pixel at that point, governed by pattern bit 0.
- R10: `patCount` = 15 with `pattern` = 0xFFFF writes every pixel in the foreground colour. `patCount` = 15 with `pattern` = 0x00FF gives repeating runs of 8 on pixels and 8 off pixels.
- R11: `pixWe` is never high while `pixValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a draw (sampled while idle) |
| x0 | input | COORD_W | Start X |
| y0 | input | COORD_W | Start Y |
| x1 | input | COORD_W | End X |
| y1 | input | COORD_W | End Y |
| errInitX | input | FRAC_W | Accumulator seed used when Y is major |
| errInitY | input | FRAC_W | Accumulator seed used when X is major |
| pattern | input | PAT_W | On/off bit per successive pixel |
| patCount | input | log2(PAT_W) | Index of the last pattern bit before wrapping |
| fgColor | input | COLOR_W | Colour of on pixels |
| bgColor | input | COLOR_W | Colour of off pixels when enabled |
| bgEnable | input | 1 | 1: paint off pixels, 0: skip them |
| busy | output | 1 | Setup or drawing in progress |
| done | output | 1 | One-cycle pulse after the last pixel |
| pixValid | output | 1 | A pixel is presented this cycle |
| pixX | output | COORD_W | Pixel X |
| pixY | output | COORD_W | Pixel Y |
| pixWe | output | 1 | Write this pixel |
| pixColor | output | COLOR_W | Colour to write |

## Verification
The bench targets lines whose |dx| equals |dy|. A design that picked the wrong major axis, or that lost the unit increment of 4096, would drift off the diagonal. It also draws lines that run toward smaller X and smaller Y, where a sign error moves pixels the wrong way, and a short wrap index of 2, where an index that runs to 15 breaks the dash period. A zero-length line checks that exactly one pixel comes out, governed by bit 0 with the background both on and off. A `start` pulse in the middle of a line checks that it neither restarts the draw nor queues a second one. The cycle right after the last pixel checks that `done` lands there and not one cycle early or late.

// File: rtl/line_raster_pkg.sv
package line_raster_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_DRAW,
    ST_DONE
  } raster_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch settings and derive deltas
    logic divStep;   // one restoring-division iteration
    logic drawStep;  // advance to the next pixel
  } raster_strobe_t;

endpackage

// File: rtl/line_raster_ctrl.sv
module line_raster_ctrl
  import line_raster_pkg::*;
#(
  parameter int DIV_CYC = 24
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           lastPix,
  output raster_strobe_t ctl,
  output logic           drawing,
  output logic           busy,
  output logic           done
);

  localparam int CNT_W = $clog2(DIV_CYC + 1);

  raster_state_t state, stateNext;
  logic [CNT_W-1:0] divCnt;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    case (state)
      ST_IDLE: if (start) begin
        ctl.load  = 1'b1;
        stateNext = ST_DIV;
      end
      ST_DIV: begin
        ctl.divStep = 1'b1;
        if (divCnt == CNT_W'(DIV_CYC - 1)) stateNext = ST_DRAW;
      end
      ST_DRAW: begin
        if (lastPix) stateNext = ST_DONE;
        else         ctl.drawStep = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load)         divCnt <= '0;
      else if (ctl.divStep) divCnt <= divCnt + 1'b1;
    end
  end

  assign drawing = (state == ST_DRAW);
  assign busy    = (state == ST_DIV) || (state == ST_DRAW);
  assign done    = (state == ST_DONE);

  // R8: completion pulse lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: no reload while a draw is in flight
  p_no_reload_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.load);

endmodule

// File: rtl/line_raster_dp.sv
module line_raster_dp
  import line_raster_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int FRAC_W  = 12,
  parameter int PAT_W   = 16,
  parameter int COLOR_W = 24,
  localparam int CNT_W  = $clog2(PAT_W),
  localparam int NUM_W  = COORD_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  raster_strobe_t     ctl,
  input  logic               drawing,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [FRAC_W-1:0]  errInitX,
  input  logic [FRAC_W-1:0]  errInitY,
  input  logic [PAT_W-1:0]   pattern,
  input  logic [CNT_W-1:0]   patCount,
  input  logic [COLOR_W-1:0] fgColor,
  input  logic [COLOR_W-1:0] bgColor,
  input  logic               bgEnable,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic               pixWe,
  output logic [COLOR_W-1:0] pixColor,
  output logic               lastPix
);

  localparam logic [COORD_W-1:0] ONE_C = COORD_W'(1);
  localparam logic [CNT_W-1:0]   ONE_I = CNT_W'(1);

  // setup-time derivations
  logic [COORD_W-1:0] adx, ady, majIn, minIn;
  logic               xMajIn;

  always_comb begin
    adx    = (x1 >= x0) ? (x1 - x0) : (x0 - x1);
    ady    = (y1 >= y0) ? (y1 - y0) : (y0 - y1);
    xMajIn = (adx >= ady);
    majIn  = xMajIn ? adx : ady;
    minIn  = xMajIn ? ady : adx;
  end

  // latched line state
  logic [COORD_W-1:0] curX, curY, major, remain;
  logic               negX, negY, xMaj;
  logic [PAT_W-1:0]   patQ;
  logic [CNT_W-1:0]   patCntQ, patIdx;
  logic [COLOR_W-1:0] fgQ, bgQ;
  logic               bgEnQ;
  logic [FRAC_W:0]    acc;

  // divider state
  logic [NUM_W-1:0]   divNum;
  logic [COORD_W:0]   divRem;
  logic [FRAC_W:0]    divQ;
  logic [COORD_W:0]   remShift;
  logic               remGe;
  logic [FRAC_W:0]    inc;

  always_comb begin
    remShift = {divRem[COORD_W-1:0], divNum[NUM_W-1]};
    remGe    = (remShift >= {1'b0, major});
    inc      = (major == '0) ? '0 : divQ;
  end

  // stepping
  logic [FRAC_W:0] accSum;
  logic            minorStep;
  logic [COORD_W-1:0] nextX, nextY;

  always_comb begin
    accSum    = acc + inc;
    minorStep = accSum[FRAC_W];
    nextX     = negX ? (curX - ONE_C) : (curX + ONE_C);
    nextY     = negY ? (curY - ONE_C) : (curY + ONE_C);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curX    <= '0;
      curY    <= '0;
      major   <= '0;
      remain  <= '0;
      negX    <= 1'b0;
      negY    <= 1'b0;
      xMaj    <= 1'b1;
      patQ    <= '0;
      patCntQ <= '0;
      patIdx  <= '0;
      fgQ     <= '0;
      bgQ     <= '0;
      bgEnQ   <= 1'b0;
      acc     <= '0;
      divNum  <= '0;
      divRem  <= '0;
      divQ    <= '0;
    end else if (ctl.load) begin
      curX    <= x0;
      curY    <= y0;
      major   <= majIn;
      remain  <= majIn;
      negX    <= (x1 < x0);
      negY    <= (y1 < y0);
      xMaj    <= xMajIn;
      patQ    <= pattern;
      patCntQ <= patCount;
      patIdx  <= '0;
      fgQ     <= fgColor;
      bgQ     <= bgColor;
      bgEnQ   <= bgEnable;
      acc     <= {1'b0, xMajIn ? errInitY : errInitX};
      divNum  <= {minIn, {FRAC_W{1'b0}}};
      divRem  <= '0;
      divQ    <= '0;
    end else if (ctl.divStep) begin
      divNum <= divNum << 1;
      divRem <= remGe ? (remShift - {1'b0, major}) : remShift;
      divQ   <= {divQ[FRAC_W-1:0], remGe};
    end else if (ctl.drawStep) begin
      acc    <= {1'b0, accSum[FRAC_W-1:0]};
      remain <= remain - ONE_C;
      patIdx <= (patIdx == patCntQ) ? '0 : (patIdx + ONE_I);
      if (xMaj) begin
        curX <= nextX;
        if (minorStep) curY <= nextY;
      end else begin
        curY <= nextY;
        if (minorStep) curX <= nextX;
      end
    end
  end

  logic onBit;
  always_comb begin
    onBit    = patQ[patIdx];
    pixX     = curX;
    pixY     = curY;
    pixWe    = drawing && (onBit || bgEnQ);
    pixColor = onBit ? fgQ : bgQ;
    lastPix  = (remain == '0);
  end

  // R2: every pixel-to-pixel move changes the major coordinate
  p_major_moves_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drawStep |=> (xMaj ? (curX != $past(curX)) : (curY != $past(curY))));

  // R5: pattern index never passes the wrap index
  p_pat_idx_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    patIdx <= patCntQ);

  // R4: accumulator holds a pure fraction between pixels
  p_acc_fraction_r4: assert property (@(posedge clk) disable iff (!rstN)
    drawing |-> !acc[FRAC_W]);

  // R4: division remainder stays below the divisor
  p_div_rem_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divStep && major != '0) |-> (divRem < {1'b0, major}));

endmodule

// File: rtl/line_raster.sv
module line_raster
  import line_raster_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int FRAC_W  = 12,
  parameter int PAT_W   = 16,
  parameter int COLOR_W = 24,
  localparam int CNT_W  = $clog2(PAT_W),
  localparam int DIV_CYC = COORD_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [FRAC_W-1:0]  errInitX,
  input  logic [FRAC_W-1:0]  errInitY,
  input  logic [PAT_W-1:0]   pattern,
  input  logic [CNT_W-1:0]   patCount,
  input  logic [COLOR_W-1:0] fgColor,
  input  logic [COLOR_W-1:0] bgColor,
  input  logic               bgEnable,
  output logic               busy,
  output logic               done,
  output logic               pixValid,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic               pixWe,
  output logic [COLOR_W-1:0] pixColor
);

  raster_strobe_t ctl;
  logic           drawing, lastPix;

  line_raster_ctrl #(.DIV_CYC(DIV_CYC)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .lastPix(lastPix),
    .ctl    (ctl),
    .drawing(drawing),
    .busy   (busy),
    .done   (done)
  );

  line_raster_dp #(
    .COORD_W(COORD_W), .FRAC_W(FRAC_W), .PAT_W(PAT_W), .COLOR_W(COLOR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .drawing (drawing),
    .x0      (x0),
    .y0      (y0),
    .x1      (x1),
    .y1      (y1),
    .errInitX(errInitX),
    .errInitY(errInitY),
    .pattern (pattern),
    .patCount(patCount),
    .fgColor (fgColor),
    .bgColor (bgColor),
    .bgEnable(bgEnable),
    .pixX    (pixX),
    .pixY    (pixY),
    .pixWe   (pixWe),
    .pixColor(pixColor),
    .lastPix (lastPix)
  );

  assign pixValid = drawing;

  // R11: writes only accompany a presented pixel
  p_we_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    pixWe |-> pixValid);

  // R8: completion is never reported while still busy
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !pixValid));

endmodule

// File: tb/line_raster_tb.sv
module line_raster_tb;

  localparam int COORD_W = 12;
  localparam int FRAC_W  = 12;
  localparam int PAT_W   = 16;
  localparam int COLOR_W = 24;
  localparam logic [COLOR_W-1:0] FG = 24'hA1B2C3;
  localparam logic [COLOR_W-1:0] BG = 24'h0F1E2D;

  typedef struct packed {
    logic [11:0] sx0, sy0, sx1, sy1;
    logic [15:0] pat;
    logic [3:0]  cnt;
    logic        bgOn;
    logic [11:0] eix, eiy;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{12'd10,  12'd10,  12'd30,  12'd15,  16'hFFFF, 4'hF, 1'b0, 12'h800, 12'h800}, // R10 solid, X major
    '{12'd100, 12'd50,  12'd60,  12'd90,  16'h00FF, 4'hF, 1'b1, 12'h800, 12'h800}, // diagonal tie, -x
    '{12'd5,   12'd200, 12'd12,  12'd100, 16'h00FF, 4'hF, 1'b0, 12'h800, 12'h800}, // Y major, -y
    '{12'd0,   12'd0,   12'd20,  12'd3,   16'h0005, 4'h2, 1'b1, 12'h000, 12'hFFF}, // short wrap, seeds
    '{12'd900, 12'd40,  12'd870, 12'd29,  16'hF0F0, 4'hF, 1'b1, 12'h800, 12'h800}, // -x -y
    '{12'd300, 12'd300, 12'd305, 12'd340, 16'h3333, 4'h7, 1'b0, 12'h123, 12'h800}  // steep Y major
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [COORD_W-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
  logic [FRAC_W-1:0]  errInitX = '0, errInitY = '0;
  logic [PAT_W-1:0]   pattern = '0;
  logic [3:0]         patCount = '0;
  logic [COLOR_W-1:0] fgColor = FG, bgColor = BG;
  logic               bgEnable = 1'b0;
  logic busy, done, pixValid, pixWe;
  logic [COORD_W-1:0] pixX, pixY;
  logic [COLOR_W-1:0] pixColor;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit hung = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  line_raster u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .x0(x0), .y0(y0), .x1(x1), .y1(y1),
    .errInitX(errInitX), .errInitY(errInitY),
    .pattern(pattern), .patCount(patCount),
    .fgColor(fgColor), .bgColor(bgColor), .bgEnable(bgEnable),
    .busy(busy), .done(done), .pixValid(pixValid),
    .pixX(pixX), .pixY(pixY), .pixWe(pixWe), .pixColor(pixColor)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Draw one line and compare every cycle against a model built from R2-R7
  task automatic runDraw(input vec_t v, input bit poke);
    int ax, ay, dx, dy, adx, ady, maj, mnr, inc, acc, idx, sgx, sgy, n, waitCyc;
    bit xm, bitOn, prevValid, sawDone;
    ax = int'(v.sx0); ay = int'(v.sy0);
    dx = int'(v.sx1) - ax; dy = int'(v.sy1) - ay;
    adx = (dx < 0) ? -dx : dx; ady = (dy < 0) ? -dy : dy;
    sgx = (dx < 0) ? -1 : 1; sgy = (dy < 0) ? -1 : 1;
    xm  = (adx >= ady);
    maj = xm ? adx : ady; mnr = xm ? ady : adx;
    inc = (maj == 0) ? 0 : (mnr * 4096) / maj;
    acc = xm ? int'(v.eiy) : int'(v.eix);
    idx = 0; n = 0; prevValid = 1'b0; sawDone = 1'b0; waitCyc = 0;

    @(negedge clk);
    x0 = v.sx0; y0 = v.sy0; x1 = v.sx1; y1 = v.sy1;
    pattern = v.pat; patCount = v.cnt; bgEnable = v.bgOn;
    errInitX = v.eix; errInitY = v.eiy;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R1", "busy after start", longint'(busy), 1);
    // change settings: must not affect the latched draw (R1)
    pattern = ~v.pat; bgEnable = ~v.bgOn; x1 = 12'd0; y1 = 12'd0;

    while (!sawDone && waitCyc < 20000) begin
      waitCyc++;
      if (pixValid) begin
        bitOn = v.pat[idx];
        check(pixX == COORD_W'(ax), "R2", "pixX", longint'(pixX), longint'(ax));
        check(pixY == COORD_W'(ay), "R4", "pixY", longint'(pixY), longint'(ay));
        check(pixWe == (bitOn | v.bgOn), bitOn ? "R6" : "R7", "pixWe",
              longint'(pixWe), longint'(bitOn | v.bgOn));
        if (pixWe)
          check(pixColor == (bitOn ? FG : BG), bitOn ? "R6" : "R7", "pixColor",
                longint'(pixColor), longint'(bitOn ? FG : BG));
        n++;
        acc += inc;
        if (xm) begin
          ax += sgx;
          if (acc >= 4096) begin ay += sgy; acc -= 4096; end
        end else begin
          ay += sgy;
          if (acc >= 4096) begin ax += sgx; acc -= 4096; end
        end
        idx = (idx == int'(v.cnt)) ? 0 : idx + 1;
        start = (poke && n == 3);  // mid-line start must be ignored (R1)
      end else begin
        start = 1'b0;
      end
      if (done) begin
        sawDone = 1'b1;
        check(n == maj + 1, "R3", "pixel count", longint'(n), longint'(maj + 1));
        check(prevValid, "R8", "done right after last pixel", longint'(prevValid), 1);
        check(busy == 1'b0, "R8", "busy with done", longint'(busy), 0);
      end
      prevValid = pixValid;
      @(negedge clk);
      start = 1'b0;
    end
    check(sawDone, "R8", "done seen", longint'(sawDone), 1);
    check(done == 1'b0, "R8", "done one cycle", longint'(done), 0);
    @(negedge clk);
    check(busy == 1'b0 && pixValid == 1'b0, "R1", "no queued draw",
          longint'(busy), 0);
  endtask

  // watchdog
  initial begin
    wait (cyc >= 150000);
    hung = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0, "R8", "reset busy", longint'(busy), 0);
    check(done == 0, "R8", "reset done", longint'(done), 0);
    check(pixValid == 0, "R3", "reset pixValid", longint'(pixValid), 0);
    check(pixWe == 0, "R11", "reset pixWe", longint'(pixWe), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC && !hung; i++) runDraw(VECS[i], i == 0);

    // R9: zero-length line, bit 0 off, background on -> one bg pixel
    if (!hung) runDraw('{12'd7, 12'd7, 12'd7, 12'd7, 16'h0002, 4'h3, 1'b1, 12'h800, 12'h800}, 1'b0);
    // R9: zero-length line, bit 0 off, background off -> no write
    if (!hung) runDraw('{12'd44, 12'd9, 12'd44, 12'd9, 16'hFFFE, 4'hF, 1'b0, 12'h800, 12'h800}, 1'b0);
    // R9: zero-length line, bit 0 on
    if (!hung) runDraw('{12'd4095, 12'd0, 12'd4095, 12'd0, 16'h0001, 4'h0, 1'b0, 12'h800, 12'h800}, 1'b0);
    // R10: 8 on / 8 off along a 40-pixel line, bg disabled
    if (!hung) runDraw('{12'd0, 12'd0, 12'd39, 12'd0, 16'h00FF, 4'hF, 1'b0, 12'h800, 12'h800}, 1'b0);
    // R5: wrap index 0 repeats bit 0 only
    if (!hung) runDraw('{12'd1, 12'd1, 12'd1, 12'd9, 16'hFFFE, 4'h0, 1'b1, 12'h800, 12'h800}, 1'b0);

    if (hung) check(1'b0, "R3", "watchdog expired", longint'(cyc), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule